// File: doc/BRIEF.md
# Link Receiver Event Interrupt Controller

This block gathers the status events of a serial link receiver into one latched, clear-on-read status byte and an active-low interrupt line. It watches three raw level inputs (clock-recovery lock and the carrier-detect levels of two inputs) and derives a "gained" event from each rising edge and a "lost" event from each falling edge. A seventh event comes from the eye monitor. It fires when a new horizontal or vertical eye-opening measurement reaches four times its programmed 4-bit threshold.

Each event has a bit in an enable register. Only enabled events are latched. The host reads the status byte with a one-cycle read strobe. The read returns the latched bits, and the whole set is cleared at the end of that cycle. An event that arrives during the read cycle is latched afresh, so it is not lost. The top bit of the status byte is not latched. It shows the current synchronized carrier-detect level of whichever input is selected.

Top module: `link_irq_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the enable register reads 0x00 and `irq_n_o` is high.
- R2: Status bit positions: 7 = selected input carrier level, 6 = lock gained, 5 = input 1 carrier gained, 4 = input 0 carrier gained, 3 = eye threshold reached, 2 = lock lost, 1 = input 1 carrier lost, 0 = input 0 carrier lost. Several events that occur together all appear in one read.
- R3: A rising edge on `lock_i` sets bit 6 and a falling edge sets bit 2, when the matching enable bit is 1.
- R4: Rising edges on `cd0_i` and `cd1_i` set bits 4 and 5. Falling edges set bits 0 and 1. Each requires its enable bit.
- R5: In a cycle with `meas_vld_i` high, bit 3 is set if `heo_i >= 4*heo_thr_i` or `veo_i >= 4*veo_thr_i`. Otherwise bit 3 is not set (for example 59 against a threshold of 15 does not set it, while 60 does).
- R6: An event whose enable bit is 0 is dropped. It does not set its bit, does not pull `irq_n_o` low, and does not appear when the enable is set later.
- R7: A write stores `en_wdata_i[6:0]` at the same positions as the status bits. Enable bit 7 always reads 0.
- R8: A read cycle returns the current status. Bits 6..0 are cleared at the end of that cycle, so a following read without new events returns 0 in those bits.
- R9: An enabled event in the same cycle as a read is latched, and it appears in the next read.
- R10: `irq_n_o` is low exactly when any of status bits 6..0 is set.
- R11: Bit 7 follows the synchronized level of `cd0_i` when `cd_sel_i` = 0 and of `cd1_i` when `cd_sel_i` = 1. Reads and enables do not affect it, and it never drives the interrupt.
- R12: A level change on a raw input is latched on the third rising clock edge after it (SYNC_STAGES + 1 edges). Latched bits stay set until read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lock_i | input | 1 | Raw clock-recovery lock level |
| cd0_i | input | 1 | Raw carrier-detect level of input 0 |
| cd1_i | input | 1 | Raw carrier-detect level of input 1 |
| cd_sel_i | input | 1 | Selected input for status bit 7 (0 = input 0, 1 = input 1) |
| meas_vld_i | input | 1 | One-cycle strobe marking a new eye measurement |
| heo_i | input | 8 | Horizontal eye opening result |
| veo_i | input | 8 | Vertical eye opening result |
| heo_thr_i | input | 4 | Horizontal threshold, compared after multiplying by 4 |
| veo_thr_i | input | 4 | Vertical threshold, compared after multiplying by 4 |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_o | output | 8 | Enable register contents |
| st_rd_i | input | 1 | Status read strobe (clears on the cycle's end) |
| st_o | output | 8 | Status byte |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults: SYNC_STAGES = 2, an 8-bit measurement width, 4-bit thresholds and a threshold shift of 2.

With these values the latency check can pin the third edge exactly. The highest threshold, 15, scales to 60 and still fits the 8-bit result, so the exact ">=" boundary (59 against 60) is reachable.

A read collides with an eye strobe in the same cycle to exercise the no-loss rule. Disabled events are followed by a late enable to show that nothing was remembered.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;
  localparam int ST_W      = 8;
  localparam int EV_W      = 7;
  localparam int N_LVL     = 3;   // index 0 = cd0, 1 = cd1, 2 = lock
  localparam int B_SEL_CD  = 7;
  localparam int B_LOCK_UP = 6;
  localparam int B_CD1_UP  = 5;
  localparam int B_CD0_UP  = 4;
  localparam int B_EYE     = 3;
  localparam int B_LOCK_DN = 2;
  localparam int B_CD1_DN  = 1;
  localparam int B_CD0_DN  = 0;

  // Place gained edges above the eye bit and lost edges below, same source order.
  function automatic logic [EV_W-1:0] pack_events(
    input logic [N_LVL-1:0] rise,
    input logic [N_LVL-1:0] fall,
    input logic             eye
  );
    return {rise, eye, fall};
  endfunction
endpackage

// File: rtl/link_irq_rst_sync.sv
module link_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[LAST];
endmodule

// File: rtl/link_irq_lvl_sync.sv
module link_irq_lvl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;

    always_comb begin
      ff_d = {ff_q[STAGES-2:0], raw_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '0;
      else        ff_q <= ff_d;
    end

    assign sync_o[b] = ff_q[LAST];
  end
endmodule

// File: rtl/link_irq_evt_gen.sv
module link_irq_evt_gen #(
  parameter int N_SRC     = 3,
  parameter int MEAS_W    = 8,
  parameter int THR_W     = 4,
  parameter int THR_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  lvl_i,
  input  logic              meas_vld_i,
  input  logic [MEAS_W-1:0] heo_i,
  input  logic [MEAS_W-1:0] veo_i,
  input  logic [THR_W-1:0]  heo_thr_i,
  input  logic [THR_W-1:0]  veo_thr_i,
  output logic [N_SRC-1:0]  rise_o,
  output logic [N_SRC-1:0]  fall_o,
  output logic              eye_o
);
  localparam int LIM_W = THR_W + THR_SHIFT;
  localparam int CMP_W = (MEAS_W > LIM_W) ? MEAS_W : LIM_W;

  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] prev_d;
  logic [CMP_W-1:0] heo_lim;
  logic [CMP_W-1:0] veo_lim;
  logic [CMP_W-1:0] heo_ext;
  logic [CMP_W-1:0] veo_ext;

  always_comb begin
    prev_d = lvl_i;
    rise_o = lvl_i & ~prev_q;
    fall_o = ~lvl_i & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    heo_lim = '0;
    veo_lim = '0;
    heo_lim[LIM_W-1:THR_SHIFT] = heo_thr_i;
    veo_lim[LIM_W-1:THR_SHIFT] = veo_thr_i;
    heo_ext = CMP_W'(heo_i);
    veo_ext = CMP_W'(veo_i);
    eye_o   = meas_vld_i && ((heo_ext >= heo_lim) || (veo_ext >= veo_lim));
  end

  // R12
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/link_irq_status.sv
module link_irq_status #(
  parameter int EV_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev_i,
  input  logic            sel_lvl_i,
  input  logic            en_wr_i,
  input  logic [EV_W:0]   en_wdata_i,
  input  logic            rd_i,
  output logic [EV_W:0]   en_o,
  output logic [EV_W:0]   st_o,
  output logic            irq_n_o
);
  logic [EV_W-1:0] en_q, en_d;
  logic [EV_W-1:0] lat_q, lat_d;
  logic            irq_n_q, irq_n_d;

  always_comb begin
    en_d    = en_wdata_i[EV_W-1:0];
    lat_d   = (rd_i ? '0 : lat_q) | (ev_i & en_q);
    irq_n_d = ~(|lat_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_wr_i) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= '0;
      irq_n_q <= 1'b1;
    end else begin
      lat_q   <= lat_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign en_o    = {1'b0, en_q};
  assign st_o    = {sel_lvl_i, lat_q};
  assign irq_n_o = irq_n_q;

  // R8
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && ((ev_i & en_q) == '0)) |=> (lat_q == '0));
  // R12
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((lat_q & $past(lat_q)) == $past(lat_q)));
  // R6
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_q == '0) && ((ev_i & en_q) == '0)) |=> (lat_q == '0));
  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_q == (lat_q == '0));
endmodule

// File: rtl/link_irq_ctrl.sv
module link_irq_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int MEAS_W      = 8,
  parameter int THR_W       = 4,
  parameter int THR_SHIFT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              cd0_i,
  input  logic              cd1_i,
  input  logic              cd_sel_i,
  input  logic              meas_vld_i,
  input  logic [MEAS_W-1:0] heo_i,
  input  logic [MEAS_W-1:0] veo_i,
  input  logic [THR_W-1:0]  heo_thr_i,
  input  logic [THR_W-1:0]  veo_thr_i,
  input  logic              en_wr_i,
  input  logic [7:0]        en_wdata_i,
  output logic [7:0]        en_o,
  input  logic              st_rd_i,
  output logic [7:0]        st_o,
  output logic              irq_n_o
);
  import link_irq_pkg::*;

  logic             srst_n;
  logic [N_LVL-1:0] lvl_raw, lvl_s, rise, fall;
  logic             eye;
  logic [EV_W-1:0]  events;
  logic             sel_lvl;

  link_irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign lvl_raw = {lock_i, cd1_i, cd0_i};

  link_irq_lvl_sync #(.WIDTH(N_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .raw_i(lvl_raw), .sync_o(lvl_s));

  link_irq_evt_gen #(.N_SRC(N_LVL), .MEAS_W(MEAS_W), .THR_W(THR_W),
                     .THR_SHIFT(THR_SHIFT)) u_evt (
    .clk(clk), .rst_n(srst_n), .lvl_i(lvl_s), .meas_vld_i(meas_vld_i),
    .heo_i(heo_i), .veo_i(veo_i), .heo_thr_i(heo_thr_i), .veo_thr_i(veo_thr_i),
    .rise_o(rise), .fall_o(fall), .eye_o(eye));

  always_comb begin
    events  = pack_events(rise, fall, eye);
    sel_lvl = cd_sel_i ? lvl_s[1] : lvl_s[0];
  end

  link_irq_status #(.EV_W(EV_W)) u_stat (
    .clk(clk), .rst_n(srst_n), .ev_i(events), .sel_lvl_i(sel_lvl),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .rd_i(st_rd_i),
    .en_o(en_o), .st_o(st_o), .irq_n_o(irq_n_o));
endmodule

// File: tb/tb_link_irq_ctrl.sv
module tb_link_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, lock_i, cd0_i, cd1_i, cd_sel_i, meas_vld_i;
  logic [7:0] heo_i, veo_i;
  logic [3:0] heo_thr_i, veo_thr_i;
  logic       en_wr_i, st_rd_i, irq_n_o;
  logic [7:0] en_wdata_i, en_o, st_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  link_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .cd0_i(cd0_i), .cd1_i(cd1_i),
    .cd_sel_i(cd_sel_i), .meas_vld_i(meas_vld_i), .heo_i(heo_i), .veo_i(veo_i),
    .heo_thr_i(heo_thr_i), .veo_thr_i(veo_thr_i), .en_wr_i(en_wr_i),
    .en_wdata_i(en_wdata_i), .en_o(en_o), .st_rd_i(st_rd_i), .st_o(st_o),
    .irq_n_o(irq_n_o));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Driver: queue the expected status, then pulse the read strobe.
  task automatic read_exp(logic [7:0] v, string req);
    exp_t e;
    e.val = v;
    e.req = req;
    exp_q.push_back(e);
    st_rd_i = 1'b1;
    tick(1);
    st_rd_i = 1'b0;
  endtask

  task automatic wr_en(logic [7:0] v);
    en_wr_i = 1'b1;
    en_wdata_i = v;
    tick(1);
    en_wr_i = 1'b0;
  endtask

  task automatic meas_pulse(logic [7:0] h, logic [7:0] v);
    heo_i = h;
    veo_i = v;
    meas_vld_i = 1'b1;
    tick(1);
    meas_vld_i = 1'b0;
    tick(1);
  endtask

  // Monitor: compare the status seen during each read cycle.
  always @(negedge clk) begin
    if (st_rd_i) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL read: actual 0x%02h expected none queued", st_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, st_o, e.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lock_i = 0; cd0_i = 0; cd1_i = 0; cd_sel_i = 0;
    meas_vld_i = 0; heo_i = 0; veo_i = 0; heo_thr_i = 4'd4; veo_thr_i = 4'd15;
    en_wr_i = 0; en_wdata_i = 0; st_rd_i = 0;
    tick(3);
    // R1
    chk("R1 status", st_o, 8'h00);
    chk("R1 enable", en_o, 8'h00);
    chk("R1 irq", {7'd0, irq_n_o}, 8'h01);
    rst_n = 1'b1;
    tick(4);
    chk("R1 status after release", st_o, 8'h00);

    // R7
    wr_en(8'hFF);
    chk("R7 enable bit7 reserved", en_o, 8'h7F);

    // R3 lock gained, R10, R8
    lock_i = 1'b1; tick(5);
    chk("R10 irq low", {7'd0, irq_n_o}, 8'h00);
    read_exp(8'h40, "R3 lock gained");
    read_exp(8'h00, "R8 cleared");
    chk("R10 irq high", {7'd0, irq_n_o}, 8'h01);
    lock_i = 1'b0; tick(5);
    read_exp(8'h04, "R3 lock lost");

    // R4 / R11 input 0
    cd0_i = 1'b1; tick(5);
    read_exp(8'h90, "R4 cd0 gained");
    read_exp(8'h80, "R11 level kept");
    cd0_i = 1'b0; tick(5);
    read_exp(8'h01, "R4 cd0 lost");

    // R4 / R11 input 1
    cd1_i = 1'b1; tick(5);
    read_exp(8'h20, "R4 cd1 gained");
    cd_sel_i = 1'b1; tick(1);
    read_exp(8'h80, "R11 select input 1");
    cd1_i = 1'b0; tick(5);
    read_exp(8'h02, "R4 cd1 lost");
    cd_sel_i = 1'b0;

    // R5 eye thresholds: heo limit 16, veo limit 60
    meas_pulse(8'd16, 8'd0);
    read_exp(8'h08, "R5 heo at limit");
    meas_pulse(8'd15, 8'd59);
    read_exp(8'h00, "R5 below both");
    meas_pulse(8'd0, 8'd60);
    read_exp(8'h08, "R5 veo at limit");

    // R2 several events together
    lock_i = 1'b1; cd0_i = 1'b1; tick(5);
    read_exp(8'hD0, "R2 combined gained");
    lock_i = 1'b0; cd0_i = 1'b0; tick(5);
    read_exp(8'h05, "R2 combined lost");

    // R12 latency: latched on the third edge
    lock_i = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    chk("R12 not yet", {7'd0, irq_n_o}, 8'h01);
    @(posedge clk); #2;
    chk("R12 third edge", {7'd0, irq_n_o}, 8'h00);
    tick(2);
    chk("R12 sticky", st_o, 8'h40);
    read_exp(8'h40, "R12 read");

    // R6 disabled events dropped
    wr_en(8'h00);
    lock_i = 1'b0; tick(5);
    chk("R6 irq stays high", {7'd0, irq_n_o}, 8'h01);
    read_exp(8'h00, "R6 masked");
    wr_en(8'h80);
    chk("R7 bit7 write", en_o, 8'h00);
    wr_en(8'h7F);
    read_exp(8'h00, "R6 not remembered");

    // R9 event during read cycle
    heo_i = 8'd16; veo_i = 8'd0;
    begin
      exp_t e;
      e.val = 8'h00;
      e.req = "R9 read during event";
      exp_q.push_back(e);
    end
    meas_vld_i = 1'b1; st_rd_i = 1'b1;
    tick(1);
    meas_vld_i = 1'b0; st_rd_i = 1'b0;
    tick(1);
    read_exp(8'h08, "R9 event kept");

    tick(3);
    chk("queue drained", 8'(exp_q.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule